// File: doc/BRIEF.md
# Die Temperature Throttle Controller

This block watches a sampled 7-bit die temperature, given in whole degrees Celsius, and compares it against three programmable limits. These are a lower throttle limit, an upper throttle limit and a trip limit. From the comparisons it produces a 2-bit throttle command, two live alarm flags and a sticky request to shut the device down. Each comparison is registered, so every output follows the temperature input one clock later.

Software sets the limits and reads back the live state through a simple 64-bit register port. A write takes effect on the clock edge where `reg_wr` is high. A read is combinational on `reg_addr`. The temperature arrives as a continuous level, not as a stream of samples: it is sampled on every clock, so it has no valid/ready handshake and applies no back-pressure. A build-time capability parameter can remove automatic throttling. In that case the controller only reports the temperature and the alarms.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: After reset, `throttle_lvl` is 00, `alarm_lo`, `alarm_hi` and `fatal_req` are 0, and the limit register at offset 0x08 reads lower limit 85, upper limit 95, trip 105, with both enables and the policy bit at 0.
- R2: Bit 32 of offset 0x08 and `alarm_lo` read 1 exactly while the temperature is at or above the lower limit (bits 6:0). They clear as soon as the temperature drops below it, and the lower enable (bit 7) does not affect them.
- R3: Bit 33 of offset 0x08 and `alarm_hi` read 1 exactly while the temperature is at or above the upper limit (bits 14:8). The upper enable (bit 15) does not affect them.
- R4: When only the enabled lower limit is reached, `throttle_lvl` is 01 (half throttle) if policy bit 44 is 1, and 10 (90 % throttle) if bit 44 is 0.
- R5: When the enabled upper limit is reached, `throttle_lvl` is 11 (full throttle), whatever the lower limit and the policy say.
- R6: A limit whose enable bit is 0 never raises `throttle_lvl`. Below every enabled limit, `throttle_lvl` is 00.
- R7: `fatal_req` rises once the temperature is at or above the trip limit (bits 30:24). It then stays high until reset, even after the temperature falls.
- R8: Offset 0x10 returns the registered temperature in bits 6:0, with zeros above.
- R9: With the no-throttle capability set, offset 0x20 reads 1 in bit 0, and `throttle_lvl` stays 00 and `fatal_req` stays 0 at any temperature. The alarms still follow their comparisons.
- R10: Writes to the status bits 33:32, to bits 63:45 and to the other unassigned bits of offset 0x08 are ignored. Writing all ones reads back as 64'h0000_1000_7F00_FFFF while both alarms are clear.
- R11: A temperature change on the input shows up on the outputs after exactly one rising clock edge, not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| temp_in | input | 7 | Sampled die temperature, whole degrees C |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr` |
| throttle_lvl | output | 2 | 00 none, 01 half, 10 90 %, 11 full |
| alarm_lo | output | 1 | Lower limit reached (live) |
| alarm_hi | output | 1 | Upper limit reached (live) |
| fatal_req | output | 1 | Sticky shutdown request |

## Verification
The hardest condition to reach from the ports is the one where a status bit is set while the throttle level it would normally drive stays off. The stimulus gets there by clearing one enable at a time and holding the temperature between the two limits, or above both. A second case needs care because the shutdown request is sticky. It is therefore exercised last on the main instance, then cleared by a second reset. A second instance, built with the no-throttle capability, is driven above every limit to show the gating.

// File: rtl/thr_pkg.sv
package thr_pkg;
  localparam int TEMP_W  = 7;
  localparam int DATA_W  = 64;

  // Byte offsets of the three registers
  localparam logic [7:0] OFF_LIMITS = 8'h08;
  localparam logic [7:0] OFF_TEMP   = 8'h10;
  localparam logic [7:0] OFF_CAPS   = 8'h20;

  // Field positions in the limit register
  localparam int LO_LSB     = 0;
  localparam int LO_EN_BIT  = 7;
  localparam int HI_LSB     = 8;
  localparam int HI_EN_BIT  = 15;
  localparam int TRIP_LSB   = 24;
  localparam int STS_LO_BIT = 32;
  localparam int STS_HI_BIT = 33;
  localparam int POLICY_BIT = 44;

  typedef enum logic [1:0] {
    THR_NONE   = 2'b00,
    THR_HALF   = 2'b01,
    THR_NINETY = 2'b10,
    THR_FULL   = 2'b11
  } thr_lvl_e;

  typedef struct packed {
    logic [TEMP_W-1:0] lo_lim;
    logic              lo_en;
    logic [TEMP_W-1:0] hi_lim;
    logic              hi_en;
    logic [TEMP_W-1:0] trip_lim;
    logic              half_policy;
  } thr_cfg_t;
endpackage

// File: rtl/thr_cfg_regs.sv
module thr_cfg_regs
  import thr_pkg::*;
#(
  parameter int LO_RST   = 85,
  parameter int HI_RST   = 95,
  parameter int TRIP_RST = 105
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output thr_cfg_t          cfg
);
  // Only the writable fields are stored; every other bit of the write is dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.lo_lim      <= TEMP_W'(LO_RST);
      cfg.lo_en       <= 1'b0;
      cfg.hi_lim      <= TEMP_W'(HI_RST);
      cfg.hi_en       <= 1'b0;
      cfg.trip_lim    <= TEMP_W'(TRIP_RST);
      cfg.half_policy <= 1'b0;
    end else if (wr_en) begin
      cfg.lo_lim      <= wdata[LO_LSB +: TEMP_W];
      cfg.lo_en       <= wdata[LO_EN_BIT];
      cfg.hi_lim      <= wdata[HI_LSB +: TEMP_W];
      cfg.hi_en       <= wdata[HI_EN_BIT];
      cfg.trip_lim    <= wdata[TRIP_LSB +: TEMP_W];
      cfg.half_policy <= wdata[POLICY_BIT];
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg)) else $error("config changed without write"); // R10
endmodule

// File: rtl/thr_compare.sv
module thr_compare
  import thr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_in,
  input  thr_cfg_t          cfg,
  output logic              hit_lo,
  output logic              hit_hi,
  output logic              hit_trip,
  output logic [TEMP_W-1:0] temp_q,
  output logic              sts_lo,
  output logic              sts_hi
);
  // Raw comparisons; enables are applied downstream only
  always_comb begin
    hit_lo   = (temp_in >= cfg.lo_lim);
    hit_hi   = (temp_in >= cfg.hi_lim);
    hit_trip = (temp_in >= cfg.trip_lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      temp_q <= '0;
      sts_lo <= 1'b0;
      sts_hi <= 1'b0;
    end else begin
      temp_q <= temp_in;
      sts_lo <= hit_lo;
      sts_hi <= hit_hi;
    end
  end
endmodule

// File: rtl/thr_level_sel.sv
module thr_level_sel
  import thr_pkg::*;
#(
  parameter bit NO_AUTO = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  thr_cfg_t cfg,
  input  logic     hit_lo,
  input  logic     hit_hi,
  input  logic     hit_trip,
  input  logic     sts_lo,
  input  logic     sts_hi,
  output thr_lvl_e lvl_q,
  output logic     fatal_q
);
  thr_lvl_e lvl_next;
  logic     trip_next;

  generate
    if (NO_AUTO) begin : g_gated
      always_comb begin
        lvl_next  = THR_NONE;
        trip_next = 1'b0;
      end
    end else begin : g_auto
      // Highest enabled level wins
      always_comb begin
        trip_next = hit_trip;
        if (hit_hi && cfg.hi_en)
          lvl_next = THR_FULL;
        else if (hit_lo && cfg.lo_en)
          lvl_next = cfg.half_policy ? THR_HALF : THR_NINETY;
        else
          lvl_next = THR_NONE;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q   <= THR_NONE;
      fatal_q <= 1'b0;
    end else begin
      lvl_q   <= lvl_next;
      fatal_q <= fatal_q | trip_next;
    end
  end

  AST_FULL_NEEDS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == THR_FULL) |-> sts_hi) else $error("full throttle without upper alarm"); // R5
  AST_LEVEL_NEEDS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q != THR_NONE) |-> (sts_lo || sts_hi)) else $error("throttle without alarm"); // R6
  AST_HALF_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q == THR_HALF) |-> $past(cfg.half_policy)) else $error("half throttle with policy 0"); // R4
  AST_FATAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_q |=> fatal_q) else $error("fatal request dropped"); // R7

  generate
    if (NO_AUTO) begin : g_chk_gated
      AST_NOCAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_q == THR_NONE) && !fatal_q) else $error("action while capability off"); // R9
    end
  endgenerate
endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
  import thr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter bit NO_AUTO  = 1'b0,
  parameter int LO_RST   = 85,
  parameter int HI_RST   = 95,
  parameter int TRIP_RST = 105
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TEMP_W-1:0] temp_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [1:0]        throttle_lvl,
  output logic              alarm_lo,
  output logic              alarm_hi,
  output logic              fatal_req
);
  thr_cfg_t          cfg;
  logic              hit_lo, hit_hi, hit_trip;
  logic [TEMP_W-1:0] temp_q;
  logic              sts_lo, sts_hi;
  thr_lvl_e          lvl_q;
  logic              fatal_q;
  logic              wr_limits;

  assign wr_limits = reg_wr && (reg_addr == ADDR_W'(OFF_LIMITS));

  thr_cfg_regs #(
    .LO_RST(LO_RST), .HI_RST(HI_RST), .TRIP_RST(TRIP_RST)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_limits), .wdata(reg_wdata), .cfg(cfg)
  );

  thr_compare u_cmp (
    .clk(clk), .rst_n(rst_n), .temp_in(temp_in), .cfg(cfg),
    .hit_lo(hit_lo), .hit_hi(hit_hi), .hit_trip(hit_trip),
    .temp_q(temp_q), .sts_lo(sts_lo), .sts_hi(sts_hi)
  );

  thr_level_sel #(.NO_AUTO(NO_AUTO)) u_sel (
    .clk(clk), .rst_n(rst_n), .cfg(cfg),
    .hit_lo(hit_lo), .hit_hi(hit_hi), .hit_trip(hit_trip),
    .sts_lo(sts_lo), .sts_hi(sts_hi),
    .lvl_q(lvl_q), .fatal_q(fatal_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_W'(OFF_LIMITS)) begin
      reg_rdata[LO_LSB +: TEMP_W]   = cfg.lo_lim;
      reg_rdata[LO_EN_BIT]          = cfg.lo_en;
      reg_rdata[HI_LSB +: TEMP_W]   = cfg.hi_lim;
      reg_rdata[HI_EN_BIT]          = cfg.hi_en;
      reg_rdata[TRIP_LSB +: TEMP_W] = cfg.trip_lim;
      reg_rdata[STS_LO_BIT]         = sts_lo;
      reg_rdata[STS_HI_BIT]         = sts_hi;
      reg_rdata[POLICY_BIT]         = cfg.half_policy;
    end else if (reg_addr == ADDR_W'(OFF_TEMP)) begin
      reg_rdata[TEMP_W-1:0] = temp_q;
    end else if (reg_addr == ADDR_W'(OFF_CAPS)) begin
      reg_rdata[0] = NO_AUTO;
    end
  end

  assign throttle_lvl = lvl_q;
  assign alarm_lo     = sts_lo;
  assign alarm_hi     = sts_hi;
  assign fatal_req    = fatal_q;

  AST_TEMP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (temp_q == $past(temp_in))) else $error("readout lag wrong"); // R11
endmodule

// File: tb/thermal_throttle_ctrl_tb_top.sv
module thermal_throttle_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  temp_in = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h08;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata, rdata_nc;
  logic [1:0]  thr, thr_nc;
  logic        a_lo, a_hi, fatal, a_lo_nc, a_hi_nc, fatal_nc;
  logic [6:0]  temp_nc = '0;
  logic        wr_nc = 1'b0;
  logic [7:0]  addr_nc = 8'h20;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  thermal_throttle_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .temp_in(temp_in), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .throttle_lvl(thr), .alarm_lo(a_lo), .alarm_hi(a_hi), .fatal_req(fatal)
  );

  thermal_throttle_ctrl #(.NO_AUTO(1'b1)) dut_nc_i (
    .clk(clk), .rst_n(rst_n), .temp_in(temp_nc), .reg_wr(wr_nc),
    .reg_addr(addr_nc), .reg_wdata(reg_wdata), .reg_rdata(rdata_nc),
    .throttle_lvl(thr_nc), .alarm_lo(a_lo_nc), .alarm_hi(a_hi_nc), .fatal_req(fatal_nc)
  );

  // {temp, expected throttle, alarm_lo, alarm_hi}; limits 60/80, both enabled, policy 1
  localparam logic [10:0] VEC [8] = '{
    {7'd10, 2'b00, 1'b0, 1'b0},
    {7'd59, 2'b00, 1'b0, 1'b0},
    {7'd60, 2'b01, 1'b1, 1'b0},
    {7'd79, 2'b01, 1'b1, 1'b0},
    {7'd80, 2'b11, 1'b1, 1'b1},
    {7'd99, 2'b11, 1'b1, 1'b1},
    {7'd70, 2'b01, 1'b1, 1'b0},
    {7'd30, 2'b00, 1'b0, 1'b0}
  };

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_limits(input logic [63:0] v);
    reg_addr  = 8'h08;
    reg_wdata = v;
    reg_wr    = 1'b1;
    step();
    reg_wr    = 1'b0;
  endtask

  function automatic logic [63:0] lim(input int lo, input bit lo_en, input int hi,
                                      input bit hi_en, input int trip, input bit pol);
    logic [63:0] v = '0;
    v[6:0] = 7'(lo); v[7] = lo_en; v[14:8] = 7'(hi); v[15] = hi_en;
    v[30:24] = 7'(trip); v[44] = pol;
    return v;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    temp_in = 7'd20;
    // R1 reset state
    check("R1 thr", 64'(thr), 64'd0);
    check("R1 fatal", 64'(fatal), 64'd0);
    check("R1 limits", reg_rdata, 64'h0000_0000_6900_5F55);
    rst_n = 1'b1;
    step();
    check("R1 alarms", 64'({a_lo, a_hi}), 64'd0);

    write_limits(lim(60, 1, 80, 1, 120, 1));
    for (int i = 0; i < 8; i++) begin
      temp_in = VEC[i][10:4];
      step();
      check("R2/R4/R5 thr", 64'(thr), 64'(VEC[i][3:2]));
      check("R2 alarm_lo", 64'(a_lo), 64'(VEC[i][1]));
      check("R3 alarm_hi", 64'(a_hi), 64'(VEC[i][0]));
    end

    // R11: no change before the edge, change after exactly one
    temp_in = 7'd65;
    #1 check("R11 before edge", 64'(thr), 64'd0);
    step();
    check("R11 after edge", 64'(thr), 64'd1);
    // R8 readout
    reg_addr = 8'h10;
    #1 check("R8 temp readout", reg_rdata, 64'd65);

    // R4 policy 0 gives 90 %
    write_limits(lim(60, 1, 80, 1, 120, 0));
    temp_in = 7'd70; step();
    check("R4 policy0", 64'(thr), 64'd2);
    // R6 upper disabled: status set, level from lower only
    write_limits(lim(60, 1, 80, 0, 120, 0));
    temp_in = 7'd85; step();
    check("R6 hi disabled thr", 64'(thr), 64'd2);
    check("R3 hi status w/o enable", 64'(a_hi), 64'd1);
    // R6 both disabled
    write_limits(lim(60, 0, 80, 0, 120, 0));
    step();
    check("R6 none enabled", 64'(thr), 64'd0);
    check("R2 lo status w/o enable", 64'(a_lo), 64'd1);

    // R10 read-only bits ignored
    temp_in = 7'd50;
    write_limits(64'hFFFF_FFFF_FFFF_FFFF);
    step();
    #1 check("R10 readback", reg_rdata, 64'h0000_1000_7F00_FFFF);

    // R7 sticky fatal
    write_limits(lim(60, 1, 80, 1, 100, 1));
    temp_in = 7'd99; step();
    check("R7 below trip", 64'(fatal), 64'd0);
    temp_in = 7'd100; step();
    check("R7 trip", 64'(fatal), 64'd1);
    temp_in = 7'd20; step(); step();
    check("R7 sticky", 64'(fatal), 64'd1);

    // R9 capability gate on the second instance
    addr_nc = 8'h08; reg_wdata = lim(10, 1, 20, 1, 30, 1); wr_nc = 1'b1;
    step(); wr_nc = 1'b0;
    temp_nc = 7'd127; step(); step();
    check("R9 thr gated", 64'(thr_nc), 64'd0);
    check("R9 fatal gated", 64'(fatal_nc), 64'd0);
    check("R9 alarms live", 64'({a_lo_nc, a_hi_nc}), 64'd3);
    addr_nc = 8'h20;
    #1 check("R9 cap bit", rdata_nc, 64'd1);

    // R1 second reset clears fatal and limits
    rst_n = 1'b0; reg_addr = 8'h08; step();
    check("R1 fatal cleared", 64'(fatal), 64'd0);
    check("R1 limits again", reg_rdata, 64'h0000_0000_6900_5F55);
    rst_n = 1'b1;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule